// File: doc/BRIEF.md
# Disk Controller I/O Address Dispatcher

This block sits between a host I/O request path and the register targets of a two-channel disk controller. Each accepted request is compared against five programmable base ranges: a command block and a control block for each of two channels, and one shared bus-master register window. The request is passed on to exactly one target with the matched base already subtracted, or it is answered locally. The block holds the base addresses and two enable flags that configuration logic writes. It also keeps one drive-select bit per channel. That bit is updated by snooping command-block writes, and it decides whether the addressed drive exists.

A request is taken in `ST_IDLE` while `req_ready` is high. The sequencer then moves to `ST_ACCESS` for one cycle. In that cycle the decoded access is presented on the target port, and the target's read data is captured. The sequencer then moves to `ST_REPLY` for one cycle, where the response is presented, and then returns to `ST_IDLE`. The transitions are unconditional except IDLE to ACCESS, which needs `req_valid`. Accesses that are blocked, dropped or invalid still pass through all three states and answer with zero data.

Top module: `disk_io_dispatch`

## Requirements
- R1: A request whose `req_size` is not 1, 2 or 4 answers with `rsp_err`=1 and `rsp_rdata`=0 and reaches no target. This check applies even while I/O space is disabled.
- R2: While I/O space is disabled, a request with a valid size reaches no target, answers with `rsp_err`=0 and `rsp_rdata`=0, and leaves the drive selects unchanged.
- R3: Windows are tested in this fixed order: primary command (`tgt_sel`=0, 8 bytes), primary control (1, 4 bytes), secondary command (2, 8 bytes), secondary control (3, 4 bytes), bus-master window (16 bytes). The first window with base ≤ address < base+span wins, and `tgt_off` = address − base.
- R4: A write to command-block offset 6 sets that channel's drive select to bit 4 of `req_wdata` (0 = master, 1 = slave). The new select takes effect for this same write, which is still forwarded. `drv_sel[0]` is the primary channel and `drv_sel[1]` the secondary.
- R5: `drive_present` bit (2×channel + select) marks an attached drive. When the selected drive is absent, command and control reads answer 0 and writes are dropped. Both cases reach no target and raise no error.
- R6: In the bus-master window, offsets 0–7 go to `tgt_sel`=4 with the offset unchanged. Offsets 8–15 go to `tgt_sel`=5 with 8 subtracted.
- R7: While bus mastering is disabled, writes to the bus-master window reach no target and answer without error. Reads of the window are still forwarded.
- R8: A base write (`cfg_base_idx` 0–4, in the window order of R3) replaces the base only when `cfg_base_data` is nonzero. A zero value leaves the old base in place.
- R9: A command-word write sets the I/O enable from bit 0 and the bus-master enable from bit 2 of `cfg_cmd_data`.
- R10: After reset: both drive selects are master, I/O and bus mastering are disabled, all bases are 0, `req_ready`=1, and `tgt_valid`=`rsp_valid`=0.
- R11: A valid-size request, with I/O enabled, whose address is in no window answers with `rsp_err`=1 and `rsp_rdata`=0 and reaches no target.
- R12: A request accepted at clock edge k is offered to its target (`tgt_valid`) in the cycle after edge k. It is answered (`rsp_valid`) in the cycle after edge k+1. `req_ready` stays low from edge k until edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base_we | input | 1 | Base-address write strobe |
| cfg_base_idx | input | 3 | Window whose base is written (0–4) |
| cfg_base_data | input | ADDR_W | New base value (ignored when zero) |
| cfg_cmd_we | input | 1 | Command-word write strobe |
| cfg_cmd_data | input | 16 | Command word; bit 0 I/O enable, bit 2 bus-master enable |
| drive_present | input | 4 | Drive attached, indexed 2×channel + select |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Dispatcher idle, request taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | I/O address |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| tgt_valid | output | 1 | Access presented to a target this cycle |
| tgt_write | output | 1 | Direction of the forwarded access |
| tgt_sel | output | 3 | Target code 0–5 (R3, R6); 7 when idle |
| tgt_off | output | ADDR_W | Offset inside the target |
| tgt_size | output | 3 | Forwarded access size |
| tgt_wdata | output | 32 | Forwarded write data |
| tgt_rdata | input | 32 | Target read data, valid in the same cycle as `tgt_valid` |
| rsp_valid | output | 1 | Response presented |
| rsp_err | output | 1 | Bad size or unmatched address |
| rsp_rdata | output | 32 | Read data, zero unless a forwarded read |
| drv_sel | output | 2 | Current drive select per channel |

## Verification
The bench uses the default parameters: a 16-bit address, 8-byte command blocks, 4-byte control blocks and a 16-byte bus-master window split at offset 8. With these spans, random offsets of up to 20 bytes past each base cross every window's upper edge and the bus-master split point, and they land in the unmatched space between windows. Programming one base on top of another brings the priority order within reach. Random drive-presence patterns and random enable words produce absent-drive reads and writes and gated bus-master writes throughout the run.

// File: rtl/dio_pkg.sv
package dio_pkg;

    localparam int NUM_WIN = 5;
    localparam int WIN_W   = 3;

    localparam int WIN_PCMD = 0;
    localparam int WIN_PCTL = 1;
    localparam int WIN_SCMD = 2;
    localparam int WIN_SCTL = 3;
    localparam int WIN_BM   = 4;

    typedef enum logic [2:0] {
        TGT_PCMD = 3'd0,
        TGT_PCTL = 3'd1,
        TGT_SCMD = 3'd2,
        TGT_SCTL = 3'd3,
        TGT_PBM  = 3'd4,
        TGT_SBM  = 3'd5,
        TGT_NONE = 3'd7
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_REPLY  = 2'd2
    } dio_state_e;

endpackage

// File: rtl/dio_cfg_regs.sv
module dio_cfg_regs
    import dio_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CMD_W  = 16,
    parameter int IO_BIT = 0,
    parameter int BM_BIT = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            base_we,
    input  logic [WIN_W-1:0]                base_idx,
    input  logic [ADDR_W-1:0]               base_data,
    input  logic                            cmd_we,
    input  logic [CMD_W-1:0]                cmd_data,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]  bases,
    output logic                            io_en,
    output logic                            bm_en
);

    // Only the two enable bits of the command word matter here.
    logic unused_cmd_bits;
    assign unused_cmd_bits = ^cmd_data;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_base
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bases[w] <= '0;
            end else if (base_we && (base_idx == WIN_W'(w)) && (base_data != '0)) begin
                bases[w] <= base_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_en <= 1'b0;
            bm_en <= 1'b0;
        end else if (cmd_we) begin
            io_en <= cmd_data[IO_BIT];
            bm_en <= cmd_data[BM_BIT];
        end
    end

endmodule

// File: rtl/dio_window_decode.sv
module dio_window_decode
    import dio_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CMD_SPAN = 8,
    parameter int CTL_SPAN = 4,
    parameter int BM_SPAN  = 16
) (
    input  logic [ADDR_W-1:0]               addr,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]  bases,
    output logic                            hit_any,
    output logic [WIN_W-1:0]                win,
    output logic [ADDR_W-1:0]               off
);

    logic [NUM_WIN-1:0] hit;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam int SPAN = (w == WIN_BM) ? BM_SPAN :
                              ((w == WIN_PCTL) || (w == WIN_SCTL)) ? CTL_SPAN : CMD_SPAN;
        logic [ADDR_W:0] limit;
        // One extra bit keeps a window at the top of the space from wrapping.
        assign limit  = {1'b0, bases[w]} + (ADDR_W+1)'(SPAN);
        assign hit[w] = (addr >= bases[w]) && ({1'b0, addr} < limit);
    end

    // Scan from the last window down so the lowest index wins.
    always_comb begin
        hit_any = |hit;
        win     = '0;
        off     = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit[w]) begin
                win = WIN_W'(w);
                off = addr - bases[w];
            end
        end
    end

endmodule

// File: rtl/dio_drive_select.sv
module dio_drive_select #(
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [CH_W-1:0]   upd_ch,
    input  logic              upd_dev,
    output logic [NUM_CH-1:0] sel
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel[c] <= 1'b0;
            end else if (upd && (upd_ch == CH_W'(c))) begin
                sel[c] <= upd_dev;
            end
        end
    end

endmodule

// File: rtl/disk_io_dispatch.sv
module disk_io_dispatch
    import dio_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int CMD_SPAN    = 8,
    parameter int CTL_SPAN    = 4,
    parameter int BM_CH_SPAN  = 8,
    parameter int SEL_OFFSET  = 6,
    parameter int SEL_DEV_BIT = 4,
    localparam int NUM_CH     = 2,
    localparam int BM_SPAN    = 2 * BM_CH_SPAN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_base_we,
    input  logic [2:0]           cfg_base_idx,
    input  logic [ADDR_W-1:0]    cfg_base_data,
    input  logic                 cfg_cmd_we,
    input  logic [15:0]          cfg_cmd_data,
    input  logic [3:0]           drive_present,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [2:0]           req_size,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 tgt_valid,
    output logic                 tgt_write,
    output logic [2:0]           tgt_sel,
    output logic [ADDR_W-1:0]    tgt_off,
    output logic [2:0]           tgt_size,
    output logic [DATA_W-1:0]    tgt_wdata,
    input  logic [DATA_W-1:0]    tgt_rdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [1:0]           drv_sel
);

    dio_state_e state_q, state_d;

    logic                 r_write;
    logic [ADDR_W-1:0]    r_addr;
    logic [2:0]           r_size;
    logic [DATA_W-1:0]    r_wdata;

    logic [NUM_WIN-1:0][ADDR_W-1:0] bases;
    logic                 io_en, bm_en;

    logic                 hit_any;
    logic [WIN_W-1:0]     win;
    logic [ADDR_W-1:0]    dec_off;

    logic                 size_ok;
    logic                 acc_fwd, acc_err, acc_upd, acc_ch, eff_dev, sel_write;
    tgt_e                 acc_tgt;
    logic [ADDR_W-1:0]    acc_off;

    logic                 rsp_err_q;
    logic [DATA_W-1:0]    rsp_rdata_q;

    dio_cfg_regs #(
        .ADDR_W (ADDR_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_we   (cfg_base_we),
        .base_idx  (cfg_base_idx),
        .base_data (cfg_base_data),
        .cmd_we    (cfg_cmd_we),
        .cmd_data  (cfg_cmd_data),
        .bases     (bases),
        .io_en     (io_en),
        .bm_en     (bm_en)
    );

    dio_window_decode #(
        .ADDR_W   (ADDR_W),
        .CMD_SPAN (CMD_SPAN),
        .CTL_SPAN (CTL_SPAN),
        .BM_SPAN  (BM_SPAN)
    ) u_dec (
        .addr    (r_addr),
        .bases   (bases),
        .hit_any (hit_any),
        .win     (win),
        .off     (dec_off)
    );

    dio_drive_select #(
        .NUM_CH (NUM_CH)
    ) u_dsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (acc_upd && (state_q == ST_ACCESS)),
        .upd_ch  (acc_ch),
        .upd_dev (eff_dev),
        .sel     (drv_sel)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: IDLE->ACCESS on request, ACCESS->REPLY, REPLY->IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_ACCESS;
            ST_ACCESS: state_d = ST_REPLY;
            ST_REPLY:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_write <= 1'b0;
            r_addr  <= '0;
            r_size  <= '0;
            r_wdata <= '0;
        end else if (req_valid && req_ready) begin
            r_write <= req_write;
            r_addr  <= req_addr;
            r_size  <= req_size;
            r_wdata <= req_wdata;
        end
    end

    assign size_ok = (r_size == 3'd1) || (r_size == 3'd2) || (r_size == 3'd4);

    // Access resolution for the captured request
    always_comb begin
        acc_fwd   = 1'b0;
        acc_err   = 1'b0;
        acc_upd   = 1'b0;
        acc_ch    = 1'b0;
        eff_dev   = 1'b0;
        sel_write = 1'b0;
        acc_tgt   = TGT_NONE;
        acc_off   = '0;
        if (!size_ok) begin
            acc_err = 1'b1;
        end else if (!io_en) begin
            acc_fwd = 1'b0;
        end else if (!hit_any) begin
            acc_err = 1'b1;
        end else begin
            unique case (win)
                WIN_W'(WIN_PCMD), WIN_W'(WIN_SCMD): begin
                    acc_ch    = (win == WIN_W'(WIN_SCMD));
                    sel_write = r_write && (dec_off == ADDR_W'(SEL_OFFSET));
                    acc_upd   = sel_write;
                    eff_dev   = sel_write ? r_wdata[SEL_DEV_BIT] : drv_sel[acc_ch];
                    acc_fwd   = drive_present[{acc_ch, eff_dev}];
                    acc_tgt   = acc_ch ? TGT_SCMD : TGT_PCMD;
                    acc_off   = dec_off;
                end
                WIN_W'(WIN_PCTL), WIN_W'(WIN_SCTL): begin
                    acc_ch  = (win == WIN_W'(WIN_SCTL));
                    eff_dev = drv_sel[acc_ch];
                    acc_fwd = drive_present[{acc_ch, eff_dev}];
                    acc_tgt = acc_ch ? TGT_SCTL : TGT_PCTL;
                    acc_off = dec_off;
                end
                WIN_W'(WIN_BM): begin
                    if (!(r_write && !bm_en)) begin
                        acc_fwd = 1'b1;
                        if (dec_off < ADDR_W'(BM_CH_SPAN)) begin
                            acc_tgt = TGT_PBM;
                            acc_off = dec_off;
                        end else begin
                            acc_tgt = TGT_SBM;
                            acc_off = dec_off - ADDR_W'(BM_CH_SPAN);
                        end
                    end
                end
                default: acc_err = 1'b1;
            endcase
        end
    end

    // Response capture at the end of ACCESS
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= '0;
        end else if (state_q == ST_ACCESS) begin
            rsp_err_q   <= acc_err;
            rsp_rdata_q <= (acc_fwd && !r_write) ? tgt_rdata : '0;
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        tgt_valid = (state_q == ST_ACCESS) && acc_fwd;
        tgt_write = r_write;
        tgt_sel   = (state_q == ST_ACCESS) ? acc_tgt : TGT_NONE;
        tgt_off   = acc_off;
        tgt_size  = r_size;
        tgt_wdata = r_wdata;
        rsp_valid = (state_q == ST_REPLY);
        rsp_err   = (state_q == ST_REPLY) && rsp_err_q;
        rsp_rdata = (state_q == ST_REPLY) ? rsp_rdata_q : '0;
    end

endmodule

// File: rtl/dio_checker.sv
module dio_checker
    import dio_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int CMD_SPAN   = 8,
    parameter int BM_CH_SPAN = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              tgt_valid,
    input logic              tgt_write,
    input logic [2:0]        tgt_sel,
    input logic [ADDR_W-1:0] tgt_off,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              io_en,
    input logic              bm_en
);

    AST_ERR_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> !$past(tgt_valid)); // R1

    AST_IO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> io_en); // R2

    AST_CMD_OFF_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && (tgt_sel == TGT_PCMD || tgt_sel == TGT_SCMD)) |-> (tgt_off < ADDR_W'(CMD_SPAN))); // R3

    AST_BM_HALF_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && (tgt_sel == TGT_PBM || tgt_sel == TGT_SBM)) |-> (tgt_off < ADDR_W'(BM_CH_SPAN))); // R6

    AST_BM_WRITE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && tgt_write && (tgt_sel == TGT_PBM || tgt_sel == TGT_SBM)) |-> bm_en); // R7

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0)); // R11

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R12

    AST_FWD_THEN_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |=> rsp_valid); // R12

endmodule

bind disk_io_dispatch dio_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CMD_SPAN   (CMD_SPAN),
    .BM_CH_SPAN (BM_CH_SPAN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .tgt_valid (tgt_valid),
    .tgt_write (tgt_write),
    .tgt_sel   (tgt_sel),
    .tgt_off   (tgt_off),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .io_en     (io_en),
    .bm_en     (bm_en)
);

// File: tb/disk_io_dispatch_tb.sv
`timescale 1ns/1ps
module disk_io_dispatch_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_base_we;
    logic [2:0]  cfg_base_idx;
    logic [15:0] cfg_base_data;
    logic        cfg_cmd_we;
    logic [15:0] cfg_cmd_data;
    logic [3:0]  drive_present;
    logic        req_valid, req_ready, req_write;
    logic [15:0] req_addr;
    logic [2:0]  req_size;
    logic [31:0] req_wdata;
    logic        tgt_valid, tgt_write;
    logic [2:0]  tgt_sel;
    logic [15:0] tgt_off;
    logic [2:0]  tgt_size;
    logic [31:0] tgt_wdata, tgt_rdata;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [1:0]  drv_sel;

    always #4 clk = ~clk;

    disk_io_dispatch u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_base_we(cfg_base_we), .cfg_base_idx(cfg_base_idx), .cfg_base_data(cfg_base_data),
        .cfg_cmd_we(cfg_cmd_we), .cfg_cmd_data(cfg_cmd_data),
        .drive_present(drive_present),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .tgt_valid(tgt_valid), .tgt_write(tgt_write), .tgt_sel(tgt_sel),
        .tgt_off(tgt_off), .tgt_size(tgt_size), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .drv_sel(drv_sel)
    );

    function automatic logic [31:0] tgt_word(input logic [2:0] s, input logic [15:0] o);
        return {5'd0, s, 8'h3C, o};
    endfunction

    assign tgt_rdata = tgt_word(tgt_sel, tgt_off);

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    bit          m_io, m_bm;
    logic [15:0] m_base [5];
    bit          m_sel  [2];
    int          spans  [5] = '{8, 4, 8, 4, 16};

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic set_base(input logic [2:0] idx, input logic [15:0] val);
        @(negedge clk);
        cfg_base_we = 1'b1; cfg_base_idx = idx; cfg_base_data = val;
        @(negedge clk);
        cfg_base_we = 1'b0;
        if (val != 16'h0) m_base[idx] = val;
    endtask

    task automatic set_cmd(input logic [15:0] val);
        @(negedge clk);
        cfg_cmd_we = 1'b1; cfg_cmd_data = val;
        @(negedge clk);
        cfg_cmd_we = 1'b0;
        m_io = val[0];
        m_bm = val[2];
    endtask

    task automatic run(input bit wr, input logic [15:0] a, input logic [2:0] sz,
                       input logic [31:0] wd, input string rq_in);
        bit          e_fwd = 1'b0;
        bit          e_err = 1'b0;
        logic [2:0]  e_sel = 3'd7;
        logic [15:0] e_off = 16'h0;
        logic [31:0] e_rd  = 32'h0;
        int          hitw  = -1;
        string       rq    = "R3";
        if (!(sz == 3'd1 || sz == 3'd2 || sz == 3'd4)) begin
            e_err = 1'b1; rq = "R1";
        end else if (!m_io) begin
            rq = "R2";
        end else begin
            for (int w = 0; w < 5; w++)
                if (hitw < 0 && int'(a) >= int'(m_base[w]) && int'(a) < int'(m_base[w]) + spans[w])
                    hitw = w;
            if (hitw < 0) begin
                e_err = 1'b1; rq = "R11";
            end else begin
                e_off = a - m_base[hitw];
                if (hitw == 4) begin
                    rq = wr ? "R7" : "R6";
                    if (!(wr && !m_bm)) begin
                        e_fwd = 1'b1;
                        if (e_off < 16'd8) e_sel = 3'd4;
                        else begin e_sel = 3'd5; e_off = e_off - 16'd8; end
                    end
                end else begin
                    int ch;
                    ch = hitw / 2;
                    if ((hitw % 2) == 0 && wr && e_off == 16'd6) begin
                        m_sel[ch] = wd[4]; rq = "R4";
                    end
                    e_fwd = drive_present[ch*2 + int'(m_sel[ch])];
                    if (!e_fwd) rq = "R5";
                    e_sel = 3'(hitw);
                end
            end
        end
        if (e_fwd && !wr) e_rd = tgt_word(e_sel, e_off);
        if (rq_in != "") rq = rq_in;

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(tgt_valid === e_fwd, rq, "tgt_valid", 32'(tgt_valid), 32'(e_fwd));
        if (e_fwd) begin
            chk(tgt_sel === e_sel, rq, "tgt_sel", 32'(tgt_sel), 32'(e_sel));
            chk(tgt_off === e_off, rq, "tgt_off", 32'(tgt_off), 32'(e_off));
            chk(tgt_write === wr, rq, "tgt_write", 32'(tgt_write), 32'(wr));
        end
        chk(rsp_valid === 1'b0 && req_ready === 1'b0, "R12", "busy in access",
            {30'd0, rsp_valid, req_ready}, 32'h0);
        @(negedge clk);
        chk(rsp_valid === 1'b1, "R12", "rsp_valid", 32'(rsp_valid), 32'h1);
        chk(rsp_err === e_err, rq, "rsp_err", 32'(rsp_err), 32'(e_err));
        chk(rsp_rdata === e_rd, rq, "rsp_rdata", rsp_rdata, e_rd);
        chk(drv_sel === {m_sel[1], m_sel[0]}, "R4", "drv_sel", 32'(drv_sel),
            32'({m_sel[1], m_sel[0]}));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_vec++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7719));
        rst_n = 1'b0;
        cfg_base_we = 0; cfg_base_idx = 0; cfg_base_data = 0;
        cfg_cmd_we = 0; cfg_cmd_data = 0;
        drive_present = 4'b1111;
        req_valid = 0; req_write = 0; req_addr = 0; req_size = 0; req_wdata = 0;
        m_io = 0; m_bm = 0; m_sel[0] = 0; m_sel[1] = 0;
        for (int i = 0; i < 5; i++) m_base[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(req_ready === 1'b1, "R10", "req_ready", 32'(req_ready), 32'h1);
        chk(rsp_valid === 1'b0 && tgt_valid === 1'b0, "R10", "idle outputs",
            {30'd0, rsp_valid, tgt_valid}, 32'h0);
        chk(drv_sel === 2'b00, "R10", "drv_sel", 32'(drv_sel), 32'h0);

        // R2 I/O disabled: read and a select write have no effect
        run(1'b0, 16'h0002, 3'd1, 32'h0, "R2");
        run(1'b1, 16'h0006, 3'd1, 32'h10, "R2");
        // R1 size error wins even with I/O disabled
        run(1'b0, 16'h0000, 3'd3, 32'h0, "R1");

        // R9 enables, R8 bases
        set_cmd(16'h0005);
        set_base(3'd0, 16'h01F0);
        set_base(3'd1, 16'h03F4);
        set_base(3'd2, 16'h0170);
        set_base(3'd3, 16'h0374);
        set_base(3'd4, 16'hC000);
        set_base(3'd0, 16'h0000);
        run(1'b0, 16'h01F3, 3'd1, 32'h0, "R8");
        run(1'b0, 16'h0000, 3'd1, 32'h0, "R11");

        // R3 each window, R6 bus-master split
        run(1'b0, 16'h03F6, 3'd1, 32'h0, "R3");
        run(1'b0, 16'h0177, 3'd2, 32'h0, "R3");
        run(1'b0, 16'h0374, 3'd4, 32'h0, "R3");
        run(1'b0, 16'hC002, 3'd1, 32'h0, "R6");
        run(1'b0, 16'hC00A, 3'd4, 32'h0, "R6");
        run(1'b0, 16'hC010, 3'd1, 32'h0, "R11");

        // R7 bus-master writes gated, reads served
        set_cmd(16'h0001);
        run(1'b1, 16'hC009, 3'd1, 32'hAA, "R7");
        run(1'b0, 16'hC009, 3'd1, 32'h0, "R7");
        set_cmd(16'h0005);
        run(1'b1, 16'hC009, 3'd1, 32'hAA, "R7");

        // R4 select snoop, R5 absent drive
        run(1'b1, 16'h01F6, 3'd1, 32'h10, "R4");
        drive_present = 4'b1101;
        run(1'b0, 16'h01F1, 3'd1, 32'h0, "R5");
        run(1'b1, 16'h03F6, 3'd1, 32'h5, "R5");
        run(1'b1, 16'h01F6, 3'd1, 32'h00, "R4");
        run(1'b1, 16'h0176, 3'd1, 32'h10, "R4");
        drive_present = 4'b0111;
        run(1'b0, 16'h0376, 3'd1, 32'h0, "R5");

        // R3 priority: secondary control placed on top of primary control
        drive_present = 4'b1111;
        set_base(3'd3, 16'h03F4);
        run(1'b0, 16'h03F5, 3'd1, 32'h0, "R3");
        set_base(3'd3, 16'h0374);

        // R1 other bad sizes
        run(1'b0, 16'h01F0, 3'd0, 32'h0, "R1");
        run(1'b1, 16'h01F0, 3'd7, 32'h0, "R1");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int w;
            logic [15:0] a;
            if (i % 40 == 0) begin
                int pick;
                pick = int'($urandom % 5);
                set_cmd(pick == 0 ? 16'h0000 : pick == 1 ? 16'h0001 :
                        pick == 2 ? 16'h0004 : 16'h0005);
                drive_present = 4'($urandom);
            end
            w = int'($urandom % 6);
            if (w < 5) a = m_base[w] + 16'($urandom % 20);
            else       a = 16'($urandom);
            run(1'($urandom), a, 3'($urandom % 5), $urandom, "");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule